// File: doc/BRIEF.md
# Address/Data Bus Demultiplexing Latch

This block sits beside a processor whose bus lines are time-shared. During the address phase, marked by a high address strobe, sixteen low lines and four upper lines together carry a 20-bit address. A further line carries the bank-high enable. During the rest of the cycle the low lines carry data. The upper lines and the bank-high line then carry status. The block recovers a stable 20-bit address and a stable bank-high enable, and it passes the data and a live status view through to the rest of the system.

When the address phase ends, the block captures the status nibble. It decodes the two segment bits into a segment identifier and into a one-hot select for four separate 1 MB memory banks. This lets code, stack, data and extra-segment traffic use physically split memories. It also keeps the interrupt-enable status bit. It raises a protocol-error flag when either of the two status bits that should be constant reads the wrong value.

Top module: `busdemux_latch`

## Requirements
- R1: While `ale` is high, `addr` equals {`ahs`, `ad`} and `bank_high` equals `bhs`, in the same cycle and without a clock edge.
- R2: While `ale` is low, `addr` and `bank_high` hold the last values seen at a clock edge with `ale` high, whatever the shared lines do.
- R3: While `ale` is low, `data_out` equals `ad` and `stat_live` equals `ahs`. While `ale` is high, both are zero.
- R4: The segment identifier is taken from `ahs[1:0]` at the first clock edge where `ale` is sampled low after being sampled high. It stays fixed until the next such edge, even if the lines change. The codes are 00 extra, 01 stack, 10 code and 11 data.
- R5: `int_en` takes the S5 status bit `ahs[2]` at the same capture edge and holds it until the next capture.
- R6: `bank_sel` is one-hot, with bit `seg_id` set, from the capture edge until the next clock edge where `ale` is sampled high. At all other times it is zero.
- R7: `proto_err` is set at the capture edge when S6 (`ahs[3]`) is 1 or S7 (`bhs`) is 0. It is cleared at that capture edge otherwise, and at any clock edge where `ale` is sampled high.
- R8: A synchronous reset clears the held address, the bank-high enable, the segment identifier, `int_en`, `bank_sel` and `proto_err` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address strobe; high during the address phase |
| ad | input | 16 | Shared address/data low lines |
| ahs | input | 4 | Shared upper address/status lines |
| bhs | input | 1 | Shared bank-high/S7 line |
| addr | output | 20 | Latched address |
| bank_high | output | 1 | Latched bank-high enable |
| data_out | output | 16 | Data pass-through |
| stat_live | output | 4 | Live status view {S6,S5,S4,S3} |
| seg_id | output | 2 | Captured segment code |
| int_en | output | 1 | Captured interrupt-enable status bit |
| bank_sel | output | 4 | One-hot 1 MB bank select |
| proto_err | output | 1 | Status protocol error |

## Verification
A fault in the held address register shows up on `addr` in the first cycle after `ale` falls. It stays visible for the whole data phase, so every cycle of that phase compares it. A stale or missed edge detector shows up one clock after the capture edge, as a wrong `seg_id` or `bank_sel`. A cycle-active flag that clears late shows up as a select still present one clock into the next address phase. The bench changes the status lines after the capture to expose a capture that is level-sensitive instead of edge-sensitive.

// File: rtl/busdemux_pkg.sv
package busdemux_pkg;
  localparam int SEG_W = 2;
  localparam int NBANK = 1 << SEG_W;

  typedef enum logic [SEG_W-1:0] {
    SEG_EXTRA = 2'b00,
    SEG_STACK = 2'b01,
    SEG_CODE  = 2'b10,
    SEG_DATA  = 2'b11
  } seg_e;

  function automatic logic [NBANK-1:0] bank_onehot(input logic [SEG_W-1:0] s);
    return NBANK'(1) << s;
  endfunction

  function automatic logic status_bad(input logic s6, input logic s7);
    return s6 | ~s7;
  endfunction
endpackage

// File: rtl/bdl_addr_hold.sv
module bdl_addr_hold #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)     held <= '0;
    else if (le) held <= d;
  end

  assign q = le ? d : held;
endmodule

// File: rtl/bdl_status_cap.sv
module bdl_status_cap
  import busdemux_pkg::*;
#(
  parameter int HI_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic [HI_W-1:0] hi,
  input  logic            s7,
  output logic            capture_evt,
  output logic [SEG_W-1:0] seg,
  output logic            ie,
  output logic            active,
  output logic            err
);
  logic ale_q;

  assign capture_evt = ale_q & ~ale;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_q  <= 1'b0;
      seg    <= '0;
      ie     <= 1'b0;
      active <= 1'b0;
      err    <= 1'b0;
    end else begin
      ale_q <= ale;
      if (capture_evt) begin
        seg    <= hi[SEG_W-1:0];
        ie     <= hi[SEG_W];
        active <= 1'b1;
        err    <= status_bad(hi[HI_W-1], s7);
      end else if (ale) begin
        active <= 1'b0;
        err    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bdl_bank_dec.sv
module bdl_bank_dec
  import busdemux_pkg::*;
(
  input  logic [SEG_W-1:0] seg,
  input  logic             active,
  output logic [NBANK-1:0] sel
);
  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    assign sel[i] = active & (seg == SEG_W'(i));
  end
endmodule

// File: rtl/busdemux_latch.sv
module busdemux_latch
  import busdemux_pkg::*;
#(
  parameter int LO_W = 16,
  parameter int HI_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ale,
  input  logic [LO_W-1:0]      ad,
  input  logic [HI_W-1:0]      ahs,
  input  logic                 bhs,
  output logic [LO_W+HI_W-1:0] addr,
  output logic                 bank_high,
  output logic [LO_W-1:0]      data_out,
  output logic [HI_W-1:0]      stat_live,
  output logic [SEG_W-1:0]     seg_id,
  output logic                 int_en,
  output logic [NBANK-1:0]     bank_sel,
  output logic                 proto_err
);
  localparam int ADDR_W = LO_W + HI_W;

  logic capture_evt;
  logic cycle_active;

  bdl_addr_hold #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .le(ale), .d({ahs, ad}), .q(addr)
  );

  bdl_addr_hold #(.W(1)) u_bhe (
    .clk(clk), .rst(rst), .le(ale), .d(bhs), .q(bank_high)
  );

  bdl_status_cap #(.HI_W(HI_W)) u_stat (
    .clk(clk), .rst(rst), .ale(ale), .hi(ahs), .s7(bhs),
    .capture_evt(capture_evt), .seg(seg_id), .ie(int_en),
    .active(cycle_active), .err(proto_err)
  );

  bdl_bank_dec u_dec (
    .seg(seg_id), .active(cycle_active), .sel(bank_sel)
  );

  assign data_out  = ale ? '0 : ad;
  assign stat_live = ale ? '0 : ahs;
endmodule

// File: rtl/busdemux_chk.sv
module busdemux_chk (
  input logic        clk,
  input logic        rst,
  input logic        ale,
  input logic [15:0] ad,
  input logic [3:0]  ahs,
  input logic        bhs,
  input logic [19:0] addr,
  input logic        bank_high,
  input logic [15:0] data_out,
  input logic [3:0]  stat_live,
  input logic [1:0]  seg_id,
  input logic        int_en,
  input logic [3:0]  bank_sel,
  input logic        proto_err,
  input logic        capture_evt
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)           age <= '0;
    else if (age != 2) age <= age + 2'd1;
  end
  logic warm;
  assign warm = (age == 2);

  assert_transparent_R1: assert property (@(posedge clk) disable iff (rst)
    ale |-> (addr == {ahs, ad}) && (bank_high == bhs));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst || !warm)
    (!ale && $past(!ale)) |-> ($stable(addr) && $stable(bank_high)));

  assert_passthru_R3: assert property (@(posedge clk) disable iff (rst)
    !ale |-> (data_out == ad) && (stat_live == ahs));

  assert_seg_capture_R4: assert property (@(posedge clk) disable iff (rst || !warm)
    capture_evt |=> (seg_id == $past(ahs[1:0])));

  assert_ie_capture_R5: assert property (@(posedge clk) disable iff (rst || !warm)
    capture_evt |=> (int_en == $past(ahs[2])));

  assert_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_sel));

  assert_idle_R6: assert property (@(posedge clk) disable iff (rst || !warm)
    (ale && $past(ale)) |-> (bank_sel == 4'b0));

  assert_err_R7: assert property (@(posedge clk) disable iff (rst || !warm)
    capture_evt |=> (proto_err == ($past(ahs[3]) || !$past(bhs))));
endmodule

bind busdemux_latch busdemux_chk u_chk (
  .clk(clk), .rst(rst), .ale(ale), .ad(ad), .ahs(ahs), .bhs(bhs),
  .addr(addr), .bank_high(bank_high), .data_out(data_out),
  .stat_live(stat_live), .seg_id(seg_id), .int_en(int_en),
  .bank_sel(bank_sel), .proto_err(proto_err), .capture_evt(capture_evt)
);

// File: tb/test_busdemux_latch.sv
module test_busdemux_latch;
  logic        clk = 1'b0;
  logic        rst;
  logic        ale;
  logic [15:0] ad;
  logic [3:0]  ahs;
  logic        bhs;
  logic [19:0] addr;
  logic        bank_high;
  logic [15:0] data_out;
  logic [3:0]  stat_live;
  logic [1:0]  seg_id;
  logic        int_en;
  logic [3:0]  bank_sel;
  logic        proto_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  busdemux_latch i_busdemux_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad(ad), .ahs(ahs), .bhs(bhs),
    .addr(addr), .bank_high(bank_high), .data_out(data_out),
    .stat_live(stat_live), .seg_id(seg_id), .int_en(int_en),
    .bank_sel(bank_sel), .proto_err(proto_err)
  );

  function automatic logic [3:0] exp_sel(input logic [1:0] s);
    logic [3:0] r;
    r = 4'b0;
    r[s] = 1'b1;
    return r;
  endfunction

  function automatic logic exp_err(input logic s6, input logic s7);
    return (s6 == 1'b1) || (s7 == 1'b0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [19:0] a, input logic bhe,
                           input logic [3:0] st, input logic s7,
                           input logic [15:0] d, input int hold);
    @(negedge clk);
    ale = 1'b1; ad = a[15:0]; ahs = a[19:16]; bhs = bhe;
    #1;
    chk("R1 addr", 32'(addr), 32'(a));
    chk("R1 bank_high", 32'(bank_high), 32'(bhe));
    chk("R3 data zero", 32'(data_out), 32'h0);
    @(negedge clk);
    chk("R6 idle sel", 32'(bank_sel), 32'h0);
    chk("R7 cleared", 32'(proto_err), 32'h0);
    ale = 1'b0; ad = d; ahs = st; bhs = s7;
    #1;
    chk("R2 addr held", 32'(addr), 32'(a));
    chk("R3 data", 32'(data_out), 32'(d));
    chk("R3 status", 32'(stat_live), 32'(st));
    @(negedge clk);
    chk("R4 seg", 32'(seg_id), 32'(st[1:0]));
    chk("R5 int_en", 32'(int_en), 32'(st[2]));
    chk("R6 sel", 32'(bank_sel), 32'(exp_sel(st[1:0])));
    chk("R7 err", 32'(proto_err), 32'(exp_err(st[3], s7)));
    for (int k = 0; k < hold; k++) begin
      ad = 16'($urandom); ahs = 4'($urandom); bhs = 1'($urandom);
      @(negedge clk);
      chk("R2 addr hold", 32'(addr), 32'(a));
      chk("R2 bhe hold", 32'(bank_high), 32'(bhe));
      chk("R4 seg hold", 32'(seg_id), 32'(st[1:0]));
      chk("R5 ie hold", 32'(int_en), 32'(st[2]));
      chk("R6 sel hold", 32'(bank_sel), 32'(exp_sel(st[1:0])));
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; ale = 1'b0; ad = '0; ahs = '0; bhs = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R8 addr", 32'(addr), 32'h0);
    chk("R8 bank_high", 32'(bank_high), 32'h0);
    chk("R8 seg", 32'(seg_id), 32'h0);
    chk("R8 sel", 32'(bank_sel), 32'h0);
    chk("R8 err", 32'(proto_err), 32'h0);
    chk("R8 int_en", 32'(int_en), 32'h0);

    // directed: each segment code, extremes of address
    bus_cycle(20'hFFFF0, 1'b0, 4'b0000, 1'b1, 16'hA5A5, 1);
    bus_cycle(20'h00000, 1'b1, 4'b0101, 1'b1, 16'h0000, 2);
    bus_cycle(20'h8_1234, 1'b0, 4'b0110, 1'b1, 16'hFFFF, 0);
    bus_cycle(20'h7_FFFF, 1'b1, 4'b0011, 1'b1, 16'h1357, 3);
    // protocol errors: S6 high, then S7 low
    bus_cycle(20'h12345, 1'b0, 4'b1010, 1'b1, 16'h2468, 1);
    bus_cycle(20'h54321, 1'b1, 4'b0001, 1'b0, 16'h9999, 1);
    bus_cycle(20'hABCDE, 1'b0, 4'b0111, 1'b1, 16'h4242, 0);

    for (int n = 0; n < 200; n++) begin
      logic [3:0] st;
      logic s7;
      st = 4'($urandom);
      if ($urandom_range(3) != 0) st[3] = 1'b0;
      s7 = ($urandom_range(3) != 0) ? 1'b1 : 1'b0;
      bus_cycle(20'($urandom), 1'($urandom), st, s7, 16'($urandom),
                int'($urandom_range(3)));
    end

    // reset in the middle of a data phase
    bus_cycle(20'hC0FFE, 1'b1, 4'b0110, 1'b1, 16'h5555, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R8 addr mid", 32'(addr), 32'h0);
    chk("R8 sel mid", 32'(bank_sel), 32'h0);
    chk("R8 seg mid", 32'(seg_id), 32'h0);
    chk("R8 bhe mid", 32'(bank_high), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule